// File: doc/BRIEF.md
# MDIO Station Management Master

This block lets software reach the management registers of external Ethernet PHYs over the two-wire MDC/MDIO bus. Software first programs an address register with the PHY port, the device number and the register number. It then writes a command/data register, and that write starts the transaction. The block divides its system clock down to MDC. It drives the MDIO line through separate value and enable outputs and reads the line back through a separate input, so the pad stays outside the block.

Each transaction is formatted as either an IEEE 802.3 Clause 22 frame or a Clause 45 frame. A small per-port selection register marks which of ports 0 to 3 speak Clause 22; every other port uses Clause 45. A Clause 45 transaction normally sends an address frame before the operation frame. A control bit can drop that address frame, so the operation reuses whatever register address the PHY already holds. A read-with-increment command also advances the stored register address, which makes a sweep over consecutive PHY registers cheap.

While a transaction runs, a busy flag reads back as 1. When the last bit has been sent, busy clears, and on reads the PHY's 16-bit answer sits in the data field.

Top module: `mdio_master`

## Requirements
- R1: Registers sit at three offsets. Offset 0 is the address register, which stores bits 25:0 and reads back zero above them. Offset 1 is the command/data register. Offset 2 is the Clause 22 port-select register. After reset all three read back zero, MDC is low and the MDIO output enable is low.
- R2: Command/data register fields: bits 15:0 hold the data, bits 17:16 the operation (1 write, 2 read with post-increment, 3 read), bit 18 skips the address frame, bits 21:19 select the clock divider, and bit 22 is busy. A write with bit 22 set and a non-zero operation starts a transaction. Busy reads back 1 until the transaction completes and 0 afterwards.
- R3: MDC stays low while the block is idle. During a transaction, each MDC half-period lasts (divider select + 1) × DIV_BASE system clocks.
- R4: A Clause 45 transaction sends an address frame and then an operation frame. Each frame is 32 ones, then start 00, then an opcode, the 5-bit port (address bits 20:16), the 5-bit device (bits 25:21), turnaround 10 and 16 data bits, all sent MSB first. The address frame has opcode 00 and carries address bits 15:0. The operation frame has opcode 01 for a write, 10 for a read with increment and 11 for a read.
- R5: A Clause 22 transaction sends a single frame: 32 ones, start 01, opcode 01 for a write or 10 for a read, the port, the register number (address bits 4:0), turnaround 10 and the data.
- R6: The port-select register keeps only bits 3:0. A transaction uses Clause 22 when the port is below 4 and the bit for that port is set; otherwise it uses Clause 45.
- R7: With the skip bit set, a Clause 45 transaction sends only the operation frame (64 MDC cycles).
- R8: In a read frame the output enable is low from the two turnaround bits to the end of the frame. The 16 data bits are sampled at MDC rising edges, and the result appears in bits 15:0 once busy clears.
- R9: A Clause 45 read with increment adds one to address bits 15:0 when it completes, wrapping 0xFFFF to 0x0000. The other address bits are unchanged. In Clause 22 mode, operation 2 is a plain read and the address is not changed.
- R10: Writes to any register while busy is set are ignored.
- R11: MDIO output and enable change only while MDC is low, and busy clears with MDC low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven when enabled |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value from the pad |

## Verification
Each frame is captured bit by bit at MDC rising edges, together with the output enable, and compared against frames built from the requirements. A bad frame-phase or bit-counter state therefore shows up as a wrong bit, a wrong frame count or a wrong enable window within the same transaction. A wrong busy or address state appears at the register port as soon as the transaction ends: as a stale busy flag, a missing or wrong increment, or a read-back that a write while busy has corrupted. Divider errors show up in the measured time between the first two MDC rising edges.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_BASE = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  localparam int HW = $clog2(8 * DIV_BASE + 1);

  logic [25:0] addr_q;
  logic [15:0] data_q;
  logic [1:0]  cmd_q;
  logic        skip_q;
  logic [2:0]  csel_q;
  logic        busy_q;
  logic [3:0]  c22sel_q;
  logic        aphase_q;
  logic [5:0]  bit_q;
  logic        mdc_q;
  logic [HW-1:0] div_q;
  logic [15:0] shift_q;

  logic        is_c22, rd_frame, tick, start;
  logic [HW-1:0] half_lim;
  logic [1:0]  st, op, ta;
  logic [4:0]  dr;
  logic [15:0] fdata;
  logic [63:0] frame;

  assign is_c22   = (addr_q[20:18] == 3'd0) && c22sel_q[addr_q[17:16]];
  assign rd_frame = !aphase_q && (cmd_q != 2'd1);
  assign half_lim = HW'((32'(csel_q) + 1) * DIV_BASE - 1);
  assign tick     = busy_q && (div_q == half_lim);
  assign start    = wr_en && !busy_q && (wr_addr == 2'd1) && wr_data[22] && (wr_data[17:16] != 2'd0);

  always_comb begin
    st    = 2'b00;
    op    = 2'b00;
    ta    = 2'b10;
    dr    = addr_q[25:21];
    fdata = data_q;
    if (aphase_q) begin
      fdata = addr_q[15:0];
    end else if (is_c22) begin
      st = 2'b01;
      op = (cmd_q == 2'd1) ? 2'b01 : 2'b10;
      dr = addr_q[4:0];
    end else begin
      op = (cmd_q == 2'd1) ? 2'b01 : (cmd_q == 2'd2) ? 2'b10 : 2'b11;
    end
    if (rd_frame) ta = 2'b11;
  end

  assign frame    = {32'hFFFF_FFFF, st, op, addr_q[20:16], dr, ta, fdata};
  assign mdc      = mdc_q;
  assign mdio_out = busy_q && frame[6'd63 - bit_q];
  assign mdio_oe  = busy_q && !(rd_frame && bit_q >= 6'd46);

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = {6'd0, addr_q};
      2'd1:    rd_data = {9'd0, busy_q, csel_q, skip_q, cmd_q, data_q};
      2'd2:    rd_data = {28'd0, c22sel_q};
      default: rd_data = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      data_q   <= '0;
      cmd_q    <= '0;
      skip_q   <= 1'b0;
      csel_q   <= '0;
      busy_q   <= 1'b0;
      c22sel_q <= '0;
      aphase_q <= 1'b0;
      bit_q    <= '0;
      mdc_q    <= 1'b0;
      div_q    <= '0;
      shift_q  <= '0;
    end else if (!busy_q) begin
      if (wr_en) begin
        case (wr_addr)
          2'd0: addr_q <= wr_data[25:0];
          2'd1: begin
            data_q <= wr_data[15:0];
            cmd_q  <= wr_data[17:16];
            skip_q <= wr_data[18];
            csel_q <= wr_data[21:19];
          end
          2'd2: c22sel_q <= wr_data[3:0];
          default: ;
        endcase
      end
      if (start) begin
        busy_q   <= 1'b1;
        aphase_q <= !(is_c22 || wr_data[18]);
        bit_q    <= '0;
        mdc_q    <= 1'b0;
        div_q    <= '0;
      end
    end else if (!tick) begin
      div_q <= div_q + 1'b1;
    end else begin
      div_q <= '0;
      if (!mdc_q) begin
        mdc_q <= 1'b1;
        if (rd_frame && bit_q >= 6'd48) shift_q <= {shift_q[14:0], mdio_in};
      end else begin
        mdc_q <= 1'b0;
        if (bit_q == 6'd63) begin
          bit_q <= '0;
          if (aphase_q) begin
            aphase_q <= 1'b0;
          end else begin
            busy_q <= 1'b0;
            if (rd_frame) data_q <= shift_q;
            if (cmd_q == 2'd2 && !is_c22) addr_q[15:0] <= addr_q[15:0] + 16'd1;
          end
        end else begin
          bit_q <= bit_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [1:0]  wr_addr,
  input logic        mdc,
  input logic        mdio_out,
  input logic        mdio_oe,
  input logic        busy_q,
  input logic [3:0]  c22sel_q,
  input logic [25:0] addr_q,
  input logic [1:0]  cmd_q,
  input logic        is_c22
);
  AST_IDLE_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !mdc); // R3
  AST_PORTSEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && wr_en && wr_addr == 2'd2 |=> $stable(c22sel_q)); // R10
  AST_LINE_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    mdc |-> $stable(mdio_out) && $stable(mdio_oe)); // R11
  AST_END_MDC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> !mdc); // R11
  AST_RELEASE_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !mdio_oe |-> cmd_q != 2'd1); // R8
  AST_POSTINC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) && $past(cmd_q) == 2'd2 && !$past(is_c22)
      |-> addr_q[15:0] == $past(addr_q[15:0]) + 16'd1); // R9
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .mdc(mdc), .mdio_out(mdio_out), .mdio_oe(mdio_oe), .busy_q(busy_q),
  .c22sel_q(c22sel_q), .addr_q(addr_q), .cmd_q(cmd_q), .is_c22(is_c22)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic mdc, mdio_out, mdio_oe;
  logic mdio_in = 1'b1;

  int errs = 0, checks = 0;
  logic cap_b [4096];
  logic cap_o [4096];
  int ncap = 0, base = 0;
  logic [15:0] reply = '0;
  realtime t0 = 0, t1 = 0;

  mdio_master dut (.*);

  always #2.5 clk = ~clk;

  always @(posedge mdc) begin
    int pos;
    pos = (ncap - base) % 64;
    if (ncap - base == 0) t0 = $realtime;
    if (ncap - base == 1) t1 = $realtime;
    if (ncap < 4096) begin
      cap_b[ncap] = mdio_out;
      cap_o[ncap] = mdio_oe;
    end
    if (pos >= 47 && pos <= 62) mdio_in = reply[15 - (pos - 47)];
    ncap++;
  end

  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks + 1);
    $finish;
  end

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  function automatic logic [31:0] cmdw(input logic [1:0] op, input bit skip, input logic [2:0] sel, input logic [15:0] d);
    return {9'd0, 1'b1, sel, skip, op, d};
  endfunction

  function automatic logic [63:0] frm(input logic [1:0] st, input logic [1:0] op, input logic [4:0] p,
                                      input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, st, op, p, r, 2'b10, d};
  endfunction

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      reg_rd(2'd1, v);
      if (!v[22]) return;
    end
    check(0, {tag, " busy never cleared"}, 1, 0);
  endtask

  task automatic run(input logic [31:0] c, input logic [15:0] rep, input string tag);
    base = ncap;
    reply = rep;
    reg_wr(2'd1, c);
    wait_idle(tag);
  endtask

  task automatic chk_frame(input int idx, input logic [63:0] exp, input bit rd, input string tag);
    logic [63:0] g, go, eo;
    for (int i = 0; i < 64; i++) begin
      g[63 - i]  = cap_b[base + idx * 64 + i];
      go[63 - i] = cap_o[base + idx * 64 + i];
    end
    eo = rd ? {{46{1'b1}}, 18'd0} : '1;
    check((g & eo) == (exp & eo), {tag, " frame bits"}, g & eo, exp & eo);
    check(go == eo, {tag, " output enable"}, go, eo);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 3; a++) begin
      reg_rd(a[1:0], v);
      check(v == 0, "R1 reset readback", v, 0);
    end
    check(!mdc && !mdio_oe, "R1 reset mdc/oe", {mdc, mdio_oe}, 0);
  endtask

  task automatic t_c45_write;
    logic [31:0] v;
    reg_wr(2'd0, (32'd3 << 21) | (32'd1 << 16) | 32'h0102);
    run(cmdw(2'd1, 0, 3'd3, 16'hA55A), 16'h0, "R4 c45 write");
    check(ncap - base == 128, "R4 c45 write edge count", ncap - base, 128);
    chk_frame(0, frm(2'b00, 2'b00, 5'd1, 5'd3, 16'h0102), 0, "R4 addr frame");
    chk_frame(1, frm(2'b00, 2'b01, 5'd1, 5'd3, 16'hA55A), 0, "R4 write frame");
    check((t1 - t0) / 5.0 == 8.0, "R3 mdc period sel=3", longint'((t1 - t0) / 5.0), 8);
    reg_rd(2'd1, v);
    check(v == {9'd0, 1'b0, 3'd3, 1'b0, 2'd1, 16'hA55A}, "R2 cmd reg after write", v, {9'd0, 1'b0, 3'd3, 1'b0, 2'd1, 16'hA55A});
    check(!mdc, "R3 mdc idle low", mdc, 0);
  endtask

  task automatic t_c45_read;
    logic [31:0] v;
    run(cmdw(2'd3, 0, 3'd0, 16'h0), 16'hC0DE, "R8 c45 read");
    check(ncap - base == 128, "R8 c45 read edge count", ncap - base, 128);
    chk_frame(1, frm(2'b00, 2'b11, 5'd1, 5'd3, 16'h0), 1, "R8 read frame");
    check((t1 - t0) / 5.0 == 2.0, "R3 mdc period sel=0", longint'((t1 - t0) / 5.0), 2);
    reg_rd(2'd1, v);
    check(v[15:0] == 16'hC0DE && !v[22], "R8 read data", v, 32'hC0DE);
    reg_rd(2'd0, v);
    check(v[15:0] == 16'h0102, "R9 plain read keeps address", v, 32'h0102);
  endtask

  task automatic t_postinc;
    logic [31:0] v;
    reg_wr(2'd0, (32'd7 << 21) | (32'd9 << 16) | 32'hFFFF);
    run(cmdw(2'd2, 0, 3'd0, 16'h0), 16'h0F0F, "R9 postinc");
    chk_frame(0, frm(2'b00, 2'b00, 5'd9, 5'd7, 16'hFFFF), 0, "R9 addr frame");
    chk_frame(1, frm(2'b00, 2'b10, 5'd9, 5'd7, 16'h0), 1, "R9 inc frame");
    reg_rd(2'd0, v);
    check(v == ((32'd7 << 21) | (32'd9 << 16)), "R9 address wrap", v, (32'd7 << 21) | (32'd9 << 16));
    reg_rd(2'd1, v);
    check(v[15:0] == 16'h0F0F, "R8 postinc read data", v[15:0], 16'h0F0F);
  endtask

  task automatic t_skip;
    logic [31:0] v;
    run(cmdw(2'd3, 1, 3'd1, 16'h0), 16'h1357, "R7 skip");
    check(ncap - base == 64, "R7 skip edge count", ncap - base, 64);
    chk_frame(0, frm(2'b00, 2'b11, 5'd9, 5'd7, 16'h0), 1, "R7 skip frame");
    reg_rd(2'd1, v);
    check(v[15:0] == 16'h1357, "R7 skip read data", v[15:0], 16'h1357);
  endtask

  task automatic t_c22;
    logic [31:0] v;
    reg_wr(2'd2, 32'hFF);
    reg_rd(2'd2, v);
    check(v == 32'hF, "R6 port reg width", v, 32'hF);
    reg_wr(2'd2, 32'h4);
    reg_wr(2'd0, (32'd2 << 16) | 32'd5);
    run(cmdw(2'd1, 0, 3'd0, 16'hA5A5), 16'h0, "R5 c22 write");
    check(ncap - base == 64, "R5 c22 edge count", ncap - base, 64);
    chk_frame(0, frm(2'b01, 2'b01, 5'd2, 5'd5, 16'hA5A5), 0, "R5 c22 write");
    reg_wr(2'd0, (32'd2 << 16) | 32'd3);
    run(cmdw(2'd2, 0, 3'd0, 16'h0), 16'h5A3C, "R9 c22 read");
    chk_frame(0, frm(2'b01, 2'b10, 5'd2, 5'd3, 16'h0), 1, "R5 c22 read");
    reg_rd(2'd1, v);
    check(v[15:0] == 16'h5A3C, "R8 c22 read data", v[15:0], 16'h5A3C);
    reg_rd(2'd0, v);
    check(v == ((32'd2 << 16) | 32'd3), "R9 c22 no increment", v, (32'd2 << 16) | 32'd3);
    reg_wr(2'd2, 32'hF);
    reg_wr(2'd0, (32'd5 << 16) | 32'd3);
    run(cmdw(2'd1, 0, 3'd0, 16'h1111), 16'h0, "R6 port5");
    check(ncap - base == 128, "R6 port5 uses c45", ncap - base, 128);
    chk_frame(1, frm(2'b00, 2'b01, 5'd5, 5'd0, 16'h1111), 0, "R6 port5 frame");
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v;
    reg_wr(2'd2, 32'h0);
    reg_wr(2'd0, (32'd4 << 16) | 32'h0042);
    base = ncap;
    reply = 16'h0;
    reg_wr(2'd1, cmdw(2'd1, 1, 3'd0, 16'h1234));
    repeat (20) @(negedge clk);
    reg_wr(2'd1, cmdw(2'd3, 0, 3'd5, 16'hBEEF));
    reg_wr(2'd0, 32'h0);
    reg_wr(2'd2, 32'hF);
    wait_idle("R10 busy");
    chk_frame(0, frm(2'b00, 2'b01, 5'd4, 5'd0, 16'h1234), 0, "R10 frame kept");
    reg_rd(2'd1, v);
    check(v == {9'd0, 1'b0, 3'd0, 1'b1, 2'd1, 16'h1234}, "R10 cmd reg kept", v, {9'd0, 1'b0, 3'd0, 1'b1, 2'd1, 16'h1234});
    reg_rd(2'd0, v);
    check(v == ((32'd4 << 16) | 32'h0042), "R10 address kept", v, (32'd4 << 16) | 32'h0042);
    reg_rd(2'd2, v);
    check(v == 0, "R10 port reg kept", v, 0);
    repeat (10) @(negedge clk);
    check(ncap - base == 64, "R2 no second transaction", ncap - base, 64);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_c45_write();
    t_c45_read();
    t_postinc();
    t_skip();
    t_c22();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule